// File: doc/BRIEF.md
# Event timer comparator channel

This block is one compare channel of a multi-channel event timer. It watches a shared 64-bit tick count, which is produced elsewhere, and raises a one-cycle `fire` strobe when the count reaches a programmed compare value. Software programs the channel through a 32-bit write port. The port selects either the control field or one half of the 64-bit compare register.

A channel runs in one of two ways. In one-shot mode it fires once per arming. In periodic mode it reloads itself from a hidden period register, so that it fires at a fixed spacing. A set-value control bit lets a periodic channel take a direct compare load. A narrow mode limits the compare value, the period and the match to the low 32 bits. In narrow one-shot mode the channel also signals when those low 32 bits roll over.

Interrupt routing, status flags and the counter itself sit outside this block.

Top module: `evt_cmp_channel`

## Requirements
- R1: `wr_sel` selects the target of a write: 0 is control, 1 is compare bits 31:0, 2 is compare bits 63:32. The control field uses bit 0 for channel enable, bit 1 for periodic, bit 2 for set-value and bit 3 for narrow. A compare write loads the selected half of the compare register when the channel is in one-shot mode, or when it is periodic with set-value set. `cmp_value` shows the new half one cycle after the write.
- R2: In periodic mode, every compare write also loads the same half of the hidden period register. The top bit of the period is forced to zero: bit 31 in narrow mode, bit 63 otherwise.
- R3: The set-value bit clears itself after any write to either compare half. A second write that is not preceded by a fresh set-value therefore leaves a periodic compare value unchanged.
- R4: A periodic channel with a nonzero period fires on a match and adds the period to the compare value at that clock edge. While the count stays at or past the compare value, judged by the sign of the wrapped difference, the compare value gains one period per cycle until it is ahead again. No strobe is produced during this catch-up.
- R5: In narrow mode the match uses only bits 31:0. Setting the narrow bit clears the upper halves of the compare and period registers, and writes to the upper compare half are ignored.
- R6: In narrow one-shot mode, an armed channel fires once when the low 32 bits of the count roll over from all ones to zero. It stays armed for its compare match. Wide mode never fires on a rollover.
- R7: The channel arms on any one of three events: a control write that sets the enable bit while the global enable is high, a compare write while both enables are high, or a rising global enable while the channel is enabled. Clearing the enable bit, or a low global enable, disarms it.
- R8: After reset the compare value is all ones, the period is zero, the control field is zero, and the channel is disarmed with no rollover pending.
- R9: `fire` goes high combinationally in the cycle in which the count matches the compare value while the channel is armed and the global enable is high. A one-shot channel disarms after a match strobe.
- R10: A periodic channel whose period is zero fires once on a match, does not reload, and disarms like a one-shot channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 compare low half, 2 compare high half |
| wr_data | input | 32 | Write data |
| count | input | 64 | Shared free-running tick count |
| glb_en | input | 1 | Global enable of the timer block |
| fire | output | 1 | One-cycle expiry strobe |
| cmp_value | output | 64 | Current compare register |

## Verification
The assertions assume three things about the inputs. First, a register write never lands in the same cycle as a match that the assertion relies on. Second, the count either holds or moves, but does not pass exactly over the compare value during a write. Third, the control field changes only through the write port. The stimulus steps the count at falling edges to values chosen to sit just below, on and just above each expected compare point. Every register write is made while the count is away from the compare value, so arming, reload and rollover events each occur in a cycle of their own.

// File: rtl/evt_cmp_pkg.sv
// Shared types for the event timer compare channel.
// Assumes the control field occupies the low CFG_FIELD_W bits of a write.
package evt_cmp_pkg;

    localparam int CFG_FIELD_W = 4;

    typedef enum logic [1:0] {
        SEL_CFG    = 2'd0,
        SEL_CMP_LO = 2'd1,
        SEL_CMP_HI = 2'd2,
        SEL_NONE   = 2'd3
    } wsel_e;

    // Packed order: bit 3 narrow, bit 2 set-value, bit 1 periodic, bit 0 enable
    typedef struct packed {
        logic narrow;
        logic setv;
        logic periodic;
        logic en;
    } chan_cfg_t;

endpackage

// File: rtl/evt_cfg_reg.sv
// Control field of one compare channel.
// Holds enable, periodic, set-value and narrow bits, and flags the edges of
// enable and narrow in the cycle of a control write.
// Assumes cfg_we and cmp_we are never high together.
module evt_cfg_reg
    import evt_cmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_we,
    input  logic      cmp_we,
    input  chan_cfg_t wcfg,
    output chan_cfg_t cfg,
    output logic      os_narrow_next,
    output logic      en_rise,
    output logic      en_fall,
    output logic      narrow_set
);

    // Control register: full load on a control write, set-value drop on a compare write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_we) begin
            cfg <= wcfg;
        end else if (cmp_we) begin
            cfg.setv <= 1'b0;
        end
    end

    // Edge flags and the narrow one-shot mode that will apply after this cycle
    always_comb begin
        en_rise        = cfg_we && wcfg.en && !cfg.en;
        en_fall        = cfg_we && !wcfg.en && cfg.en;
        narrow_set     = cfg_we && wcfg.narrow;
        os_narrow_next = cfg_we ? (wcfg.narrow && !wcfg.periodic)
                                : (cfg.narrow && !cfg.periodic);
    end

    // R3
    setv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |=> !cfg.setv);

    // R8
    cfg_reset_chk: assert property (@(posedge clk)
        !rst_n |=> cfg == '0);

endmodule

// File: rtl/evt_cmp_store.sv
// Compare and hidden period registers of one channel.
// Handles half-word loads, narrow truncation, and the periodic advance.
// The advance adds one period per cycle while the count is not ahead.
// Assumes CNT_W == 2 * WR_W.
module evt_cmp_store #(
    parameter int CNT_W = 64,
    parameter int WR_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             periodic,
    input  logic             setv,
    input  logic             narrow,
    input  logic             lo_we,
    input  logic             hi_we,
    input  logic [WR_W-1:0]  wdata,
    input  logic             narrow_set,
    input  logic             armed,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cmp_q,
    output logic             period_nz
);

    localparam int HI_W = CNT_W - WR_W;

    logic [CNT_W-1:0] period_q;
    logic [WR_W-1:0]  wdata_clamp;
    logic [CNT_W-1:0] diff_wide;
    logic [WR_W-1:0]  diff_narrow;
    logic [CNT_W-1:0] sum_wide;
    logic [CNT_W-1:0] sum_next;
    logic             load_cmp;
    logic             not_ahead;
    logic             adv;

    // Wrapped distance, reload sum and the advance decision
    always_comb begin
        wdata_clamp = {1'b0, wdata[WR_W-2:0]};
        load_cmp    = !periodic || setv;
        diff_wide   = count - cmp_q;
        diff_narrow = count[WR_W-1:0] - cmp_q[WR_W-1:0];
        not_ahead   = narrow ? !diff_narrow[WR_W-1] : !diff_wide[CNT_W-1];
        period_nz   = |period_q;
        sum_wide    = cmp_q + period_q;
        sum_next    = narrow ? {{HI_W{1'b0}}, sum_wide[WR_W-1:0]} : sum_wide;
        adv         = armed && periodic && period_nz && not_ahead
                      && !lo_we && !hi_we && !narrow_set;
    end

    // Register update: truncation, then half writes, then periodic advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q    <= '1;
            period_q <= '0;
        end else if (narrow_set) begin
            cmp_q[CNT_W-1:WR_W]    <= '0;
            period_q[CNT_W-1:WR_W] <= '0;
        end else if (lo_we) begin
            if (load_cmp) begin
                cmp_q[WR_W-1:0] <= wdata;
            end
            if (periodic) begin
                period_q[WR_W-1:0] <= narrow ? wdata_clamp : wdata;
            end
        end else if (hi_we && !narrow) begin
            if (load_cmp) begin
                cmp_q[CNT_W-1:WR_W] <= wdata;
            end
            if (periodic) begin
                period_q[CNT_W-1:WR_W] <= wdata_clamp;
            end
        end else if (adv) begin
            cmp_q <= sum_next;
        end
    end

    // R2
    period_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_q[CNT_W-1]);

    // R5
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        narrow |-> (cmp_q[CNT_W-1:WR_W] == '0 && period_q[CNT_W-1:WR_W] == '0));

    // R10
    zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (periodic && !period_nz && !lo_we && !hi_we && !narrow_set) |=> $stable(cmp_q));

    // R4
    periodic_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && periodic && period_nz && !narrow && !lo_we && !hi_we
         && !narrow_set && count == cmp_q) |=> cmp_q != $past(cmp_q));

    // R8
    store_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (cmp_q == '1 && period_q == '0));

endmodule

// File: rtl/evt_fire_logic.sv
// Arming state, match detection, rollover detection and the fire strobe.
// Assumes the count input is registered upstream, so fire may depend on it
// combinationally.
module evt_fire_logic #(
    parameter int CNT_W = 64,
    parameter int WR_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             periodic,
    input  logic             narrow,
    input  logic             os_narrow_next,
    input  logic             en_rise,
    input  logic             en_fall,
    input  logic             cmp_we,
    input  logic             glb_en,
    input  logic             period_nz,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_q,
    output logic             armed,
    output logic             fire
);

    logic            wrap_pend;
    logic            prev_ok;
    logic            glb_q;
    logic [WR_W-1:0] prev_low;
    logic            match;
    logic            wrap_hit;
    logic            glb_rise;
    logic            arm_req;
    logic            single;

    // Match, rollover and arming requests
    always_comb begin
        match    = narrow ? (count[WR_W-1:0] == cmp_q[WR_W-1:0]) : (count == cmp_q);
        wrap_hit = wrap_pend && narrow && !periodic && prev_ok
                   && (&prev_low) && (count[WR_W-1:0] == '0);
        fire     = armed && glb_en && (match || wrap_hit);
        glb_rise = glb_en && !glb_q;
        arm_req  = glb_en && (en_rise || (glb_rise && en) || (cmp_we && en));
        single   = !periodic || !period_nz;
    end

    // Arming state and history of the count and global enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            wrap_pend <= 1'b0;
            prev_ok   <= 1'b0;
            prev_low  <= '0;
            glb_q     <= 1'b0;
        end else begin
            prev_ok  <= 1'b1;
            prev_low <= count[WR_W-1:0];
            glb_q    <= glb_en;
            if (en_fall || !glb_en) begin
                armed     <= 1'b0;
                wrap_pend <= 1'b0;
            end else if (arm_req) begin
                armed     <= 1'b1;
                wrap_pend <= os_narrow_next;
            end else if (fire) begin
                if (match && single) begin
                    armed     <= 1'b0;
                    wrap_pend <= 1'b0;
                end else if (!match) begin
                    wrap_pend <= 1'b0;
                end
            end
        end
    end

    // R7
    arm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(glb_en));

    // R7
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall |=> !armed);

    // R9
    oneshot_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && match && single && !arm_req) |=> !armed);

    // R6
    wrap_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !match && !arm_req) |=> (!wrap_pend && armed));

    // R8
    fire_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!armed && !wrap_pend));

endmodule

// File: rtl/evt_cmp_channel.sv
// Top of one event timer compare channel.
// Decodes the write port and joins the control register, the compare/period
// store and the fire logic.
// Assumes count advances elsewhere and that WR_W is half of CNT_W.
module evt_cmp_channel
    import evt_cmp_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int WR_W  = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WR_W-1:0]  wr_data,
    input  logic [CNT_W-1:0] count,
    input  logic             glb_en,
    output logic             fire,
    output logic [CNT_W-1:0] cmp_value
);

    wsel_e     sel;
    chan_cfg_t wcfg;
    chan_cfg_t cfg;
    logic      cfg_we;
    logic      lo_we;
    logic      hi_we;
    logic      cmp_we;
    logic      os_narrow_next;
    logic      en_rise;
    logic      en_fall;
    logic      narrow_set;
    logic      armed;
    logic      period_nz;

    // Write port decode
    always_comb begin
        sel    = wsel_e'(wr_sel);
        wcfg   = chan_cfg_t'(wr_data[CFG_FIELD_W-1:0]);
        cfg_we = wr_en && (sel == SEL_CFG);
        lo_we  = wr_en && (sel == SEL_CMP_LO);
        hi_we  = wr_en && (sel == SEL_CMP_HI);
        cmp_we = lo_we || hi_we;
    end

    evt_cfg_reg u_cfg (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cmp_we         (cmp_we),
        .wcfg           (wcfg),
        .cfg            (cfg),
        .os_narrow_next (os_narrow_next),
        .en_rise        (en_rise),
        .en_fall        (en_fall),
        .narrow_set     (narrow_set)
    );

    evt_cmp_store #(.CNT_W(CNT_W), .WR_W(WR_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .periodic   (cfg.periodic),
        .setv       (cfg.setv),
        .narrow     (cfg.narrow),
        .lo_we      (lo_we),
        .hi_we      (hi_we),
        .wdata      (wr_data),
        .narrow_set (narrow_set),
        .armed      (armed),
        .count      (count),
        .cmp_q      (cmp_value),
        .period_nz  (period_nz)
    );

    evt_fire_logic #(.CNT_W(CNT_W), .WR_W(WR_W)) u_fire (
        .clk            (clk),
        .rst_n          (rst_n),
        .en             (cfg.en),
        .periodic       (cfg.periodic),
        .narrow         (cfg.narrow),
        .os_narrow_next (os_narrow_next),
        .en_rise        (en_rise),
        .en_fall        (en_fall),
        .cmp_we         (cmp_we),
        .glb_en         (glb_en),
        .period_nz      (period_nz),
        .count          (count),
        .cmp_q          (cmp_value),
        .armed          (armed),
        .fire           (fire)
    );

endmodule

// File: tb/evt_cmp_channel_test.sv
// Directed sweep bench for the compare channel; expected values are computed here.
module evt_cmp_channel_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [63:0] count = '0;
    logic        glb_en = 1'b0;
    logic        fire;
    logic [63:0] cmp_value;

    int n_chk = 0;
    int n_fail = 0;

    evt_cmp_channel uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .count     (count),
        .glb_en    (glb_en),
        .fire      (fire),
        .cmp_value (cmp_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One register write; returns at the falling edge after it took effect
    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    // New count at a falling edge, outputs settle before the next rising edge
    task automatic setc(input logic [63:0] v);
        @(negedge clk);
        count = v;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R8 compare after reset", cmp_value, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R8 no strobe after reset", {63'd0, fire}, 64'd0);

        // Zero period periodic: fires once, no reload
        @(negedge clk); glb_en = 1'b1;
        wr(2'd0, 32'h3);
        setc(64'hFFFF_FFFF_FFFF_FFFF);
        chk("R10 zero-period match fires", {63'd0, fire}, 64'd1);
        setc(64'hFFFF_FFFF_FFFF_FFFF);
        chk("R10 zero-period no second strobe", {63'd0, fire}, 64'd0);
        chk("R8 period zero keeps compare", cmp_value, 64'hFFFF_FFFF_FFFF_FFFF);

        // Arming gated by global enable
        wr(2'd0, 32'h0);
        @(negedge clk); glb_en = 1'b0;
        wr(2'd0, 32'h1);
        setc(64'd4);
        wr(2'd1, 32'd5);
        wr(2'd2, 32'd0);
        chk("R1 one-shot compare load", cmp_value, 64'd5);
        setc(64'd5);
        chk("R7 no arm while global off", {63'd0, fire}, 64'd0);
        @(negedge clk); glb_en = 1'b1;
        setc(64'd5);
        chk("R7 global rise arms enabled channel", {63'd0, fire}, 64'd1);
        setc(64'd5);
        chk("R9 one-shot disarms after match", {63'd0, fire}, 64'd0);

        // Enable bit clear and set
        setc(64'd19);
        wr(2'd1, 32'd20);
        wr(2'd0, 32'h0);
        setc(64'd20);
        chk("R7 cleared enable disarms", {63'd0, fire}, 64'd0);
        wr(2'd0, 32'h1);
        chk("R7 enable set arms", {63'd0, fire}, 64'd1);
        setc(64'd30);
        wr(2'd1, 32'd31);
        @(negedge clk); glb_en = 1'b0;
        setc(64'd31);
        chk("R7 no strobe with global low", {63'd0, fire}, 64'd0);
        @(negedge clk); glb_en = 1'b1;
        setc(64'd31);
        chk("R7 re-armed on global rise", {63'd0, fire}, 64'd1);
        setc(64'd32);

        // Periodic sweep with set-value load
        setc(64'd90);
        wr(2'd0, 32'h7);
        wr(2'd1, 32'd100);
        wr(2'd2, 32'd0);
        chk("R1 set-value periodic load", cmp_value, 64'd100);
        wr(2'd1, 32'd50);
        chk("R3 set-value cleared, compare kept", cmp_value, 64'd100);
        for (int k = 0; k < 16; k++) begin
            exp = 64'd100 + 64'd50 * 64'(k);
            setc(exp - 64'd1);
            chk("R4 no strobe before match", {63'd0, fire}, 64'd0);
            setc(exp);
            chk("R4 periodic match strobe", {63'd0, fire}, 64'd1);
            setc(exp + 64'd1);
            chk("R2 R4 reload by period", cmp_value, exp + 64'd50);
        end

        // Catch-up after the count jumps ahead
        exp = 64'd900;
        setc(64'd1157);
        while (!(exp > 64'd1157)) exp = exp + 64'd50;
        repeat (10) @(negedge clk);
        #1;
        chk("R4 catch-up lands ahead", cmp_value, exp);

        // Wide period top bit forced to zero
        setc(64'd5);
        wr(2'd0, 32'h7);
        wr(2'd1, 32'h10);
        wr(2'd2, 32'hFFFF_FFFF);
        chk("R3 high write without set-value", cmp_value, 64'h10);
        setc(64'h10);
        chk("R4 wide periodic strobe", {63'd0, fire}, 64'd1);
        setc(64'h11);
        chk("R2 wide period msb cleared", cmp_value, 64'h7FFF_FFFF_0000_0020);

        // Narrow truncation and ignored upper writes
        wr(2'd0, 32'h1);
        wr(2'd2, 32'h1234);
        chk("R1 one-shot high load", cmp_value, 64'h0000_1234_0000_0020);
        wr(2'd0, 32'h9);
        chk("R5 narrow clears upper compare", cmp_value, 64'h20);
        wr(2'd2, 32'hABCD);
        chk("R5 upper write ignored in narrow", cmp_value, 64'h20);
        setc(64'h5_0000_0020);
        chk("R5 narrow match on low half", {63'd0, fire}, 64'd1);

        // Narrow periodic period msb
        setc(64'h5_8000_0010);
        wr(2'd0, 32'hF);
        wr(2'd1, 32'hFFFF_FFFF);
        chk("R1 narrow set-value load", cmp_value, 64'hFFFF_FFFF);
        setc(64'h5_FFFF_FFFF);
        chk("R5 narrow periodic strobe", {63'd0, fire}, 64'd1);
        setc(64'h6_0000_0000);
        chk("R2 R5 narrow reload wraps", cmp_value, 64'h7FFF_FFFE);

        // Narrow one-shot rollover strobe
        wr(2'd0, 32'h9);
        setc(64'h6_0000_0005);
        wr(2'd1, 32'h10);
        setc(64'h6_FFFF_FFFE);
        chk("R6 no strobe before rollover", {63'd0, fire}, 64'd0);
        setc(64'h6_FFFF_FFFF);
        chk("R6 no strobe at all ones", {63'd0, fire}, 64'd0);
        setc(64'h7_0000_0000);
        chk("R6 rollover strobe", {63'd0, fire}, 64'd1);
        setc(64'h7_0000_0001);
        chk("R6 rollover strobe one cycle", {63'd0, fire}, 64'd0);
        setc(64'h7_FFFF_FFFF);
        setc(64'h8_0000_0000);
        chk("R6 second rollover silent", {63'd0, fire}, 64'd0);
        setc(64'h8_0000_0010);
        chk("R6 match after rollover", {63'd0, fire}, 64'd1);
        setc(64'h8_0000_0011);
        setc(64'h8_0000_0010);
        chk("R9 one-shot spent", {63'd0, fire}, 64'd0);

        // Wide one-shot has no rollover strobe
        wr(2'd0, 32'h1);
        wr(2'd2, 32'h0);
        setc(64'h8_FFFF_FFFF);
        setc(64'h9_0000_0000);
        chk("R6 wide mode no rollover strobe", {63'd0, fire}, 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule